// File: doc/BRIEF.md
# Slot Table Builder

This engine builds the slot schedule of a memory arbiter. The schedule has 64 slots, and each slot holds the code of a client or an empty marker. A start pulse captures three inputs: 14 per-client slot requests, 14 active flags and a count of spare slots.

The engine runs two passes over an internal table:

- **Reservation pass.** Clients are visited in ascending index order. Each client's reserved slots are spread at a fixed stride across the table. A collision pushes the placement forward to the next free slot.
- **Fill pass.** The finished table is streamed out one slot per cycle, in ascending slot order. Every slot still empty is handed round-robin to the active clients.

Clients with no request but with the active flag set are seeded with a single slot ahead of the fill. This happens only while the spare count is nonzero, and it keeps spare capacity from collecting at low client indices.

A caller puts the inputs in place and pulses start. It then consumes the 64 slot writes, which are an index and a client code qualified by a write strobe. It waits for the done pulse before starting again.

Top module: `slot_table_builder`

## Requirements
- R1: After reset, busy_o, done_o and wr_en_o are low.
- R2: start_i is accepted only while busy_o is low, and it captures req_i, active_i and unused_i. A start_i pulse or an input change while busy_o is high has no effect on the table produced.
- R3: Clients are placed in ascending index order. A client with request r > 0 takes up to r slots. The first candidate slot is 0, and each later candidate lies floor(64/r) slots past the last slot it took, with a stride of 1 when r > 64. Placement stops early at the end of the table. The active flag is ignored for clients with r > 0.
- R4: When a candidate slot is already taken, the candidate moves forward one slot at a time until a free slot is found. The stride then continues from the slot actually taken.
- R5: A client with r = 0 takes exactly one slot, placed by the R3/R4 rules starting at slot 0, when its active flag is set and unused_i is greater than 0. Otherwise it takes no slot in the reservation pass.
- R6: Each slot left empty after the reservation pass is assigned, in ascending slot order, to the first active client at or after a rotating pointer. The pointer starts at client 0 and moves to the chosen client plus one, wrapping modulo 14. Requests are ignored in this pass.
- R7: When no client is active, the leftover slots are written with the empty code 15, and the engine still completes.
- R8: The output is exactly 64 writes on consecutive cycles, with wr_idx_o running 0 to 63. wr_client_o carries a client code from 0 to 13, or 15 for an empty slot.
- R9: busy_o is high from the cycle after an accepted start through the cycle of the last write. done_o is high for exactly the next cycle, during which busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| req_i | input | 98 | Per-client slot requests, 7 bits each; client k sits at bits [7k+6:7k] |
| active_i | input | 14 | Per-client active flags, bit k for client k |
| unused_i | input | 7 | Count of spare slots; only zero versus nonzero matters |
| busy_o | output | 1 | Engine running |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Slot write strobe |
| wr_idx_o | output | 6 | Slot index of the current write |
| wr_client_o | output | 4 | Client code of the current write (15 = empty) |

## Verification
The reservation pass takes a data-dependent number of cycles. The checks therefore do not predict when the first write appears. After start_i is accepted, busy_o must read high at the next sampling point, and busy_o must stay high on every cycle until done_o. Write strobes must then arrive on consecutive cycles with ascending indices. done_o is due exactly one cycle after the write of slot 63, and it must be gone one cycle later. All outputs are sampled on the falling clock edge, so each registered result is read half a period after the edge that produced it. The captured table is compared with a model computed in the bench only after done_o has been seen.

// File: rtl/slot_builder_pkg.sv
package slot_builder_pkg;
  typedef enum logic {PL_IDLE, PL_RUN} pl_state_e;
endpackage

// File: rtl/stb_rr_pick.sv
module stb_rr_pick #(
  parameter int N_CLIENTS = 14,
  parameter int CID_W     = 4
) (
  input  logic [N_CLIENTS-1:0] active_i,
  input  logic [CID_W-1:0]     ptr_i,
  output logic                 found_o,
  output logic [CID_W-1:0]     sel_o
);
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    for (int k = 0; k < N_CLIENTS; k++) begin
      int j;
      j = int'(ptr_i) + k;
      if (j >= N_CLIENTS) j = j - N_CLIENTS;
      if (!found_o && active_i[j]) begin
        found_o = 1'b1;
        sel_o   = CID_W'(j);
      end
    end
  end
endmodule

// File: rtl/stb_placer.sv
module stb_placer
  import slot_builder_pkg::*;
#(
  parameter int N_CLIENTS = 14,
  parameter int N_SLOTS   = 64,
  parameter int REQ_W     = 7,
  parameter int CID_W     = 4,
  parameter int SLOT_W    = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [N_CLIENTS*REQ_W-1:0] req_i,
  input  logic [N_CLIENTS-1:0]       active_i,
  input  logic [REQ_W-1:0]           unused_i,
  input  logic [SLOT_W-1:0]          rd_idx_i,
  output logic [CID_W-1:0]           rd_client_o,
  output logic [N_CLIENTS-1:0]       act_o,
  output logic                       busy_o,
  output logic                       fin_o
);
  localparam int POS_W = SLOT_W + 2;
  localparam logic [CID_W-1:0] SENT = '1;
  localparam logic [CID_W-1:0] LAST = CID_W'(N_CLIENTS - 1);

  pl_state_e          state_q;
  logic [REQ_W-1:0]   req_q [N_CLIENTS];
  logic [N_CLIENTS-1:0] act_q;
  logic               spare_q;
  logic [CID_W-1:0]   cli_q;
  logic [POS_W-1:0]   pos_q;
  logic [REQ_W-1:0]   cnt_q;
  logic [CID_W-1:0]   tbl_q [N_SLOTS];

  logic [REQ_W-1:0]   cur_req, want;
  logic [POS_W-1:0]   stride;
  logic [SLOT_W-1:0]  pos_s;
  logic               adv, occ;

  always_comb begin
    int iv;
    cur_req = req_q[cli_q];
    if (cur_req != '0)                      want = cur_req;
    else if (act_q[cli_q] && spare_q)       want = REQ_W'(1);
    else                                    want = '0;
    iv = (cur_req == '0) ? N_SLOTS : N_SLOTS / int'(cur_req);
    if (iv < 1) iv = 1;
    stride = POS_W'(iv);
    adv    = (cnt_q >= want) || (pos_q >= POS_W'(N_SLOTS));
    pos_s  = pos_q[SLOT_W-1:0];
    occ    = tbl_q[pos_s] != SENT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PL_IDLE;
      act_q   <= '0;
      spare_q <= 1'b0;
      cli_q   <= '0;
      pos_q   <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < N_CLIENTS; i++) req_q[i] <= '0;
      for (int s = 0; s < N_SLOTS; s++)   tbl_q[s] <= SENT;
    end else begin
      case (state_q)
        PL_IDLE: if (start_i) begin
          for (int i = 0; i < N_CLIENTS; i++) req_q[i] <= req_i[i*REQ_W +: REQ_W];
          for (int s = 0; s < N_SLOTS; s++)   tbl_q[s] <= SENT;
          act_q   <= active_i;
          spare_q <= unused_i != '0;
          cli_q   <= '0;
          pos_q   <= '0;
          cnt_q   <= '0;
          state_q <= PL_RUN;
        end
        PL_RUN: begin
          if (adv) begin
            if (cli_q == LAST) state_q <= PL_IDLE;
            cli_q <= cli_q + 1'b1;
            pos_q <= '0;
            cnt_q <= '0;
          end else if (occ) begin
            pos_q <= pos_q + 1'b1;
          end else begin
            tbl_q[pos_s] <= cli_q;
            cnt_q        <= cnt_q + 1'b1;
            pos_q        <= pos_q + stride;
          end
        end
        default: state_q <= PL_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q == PL_RUN;
  assign fin_o       = (state_q == PL_RUN) && adv && (cli_q == LAST);
  assign rd_client_o = tbl_q[rd_idx_i];
  assign act_o       = act_q;

  // R3
  pos_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PL_RUN && $past(state_q == PL_RUN) && cli_q == $past(cli_q))
      |-> pos_q > $past(pos_q));
  // R3
  cli_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PL_RUN && $past(state_q == PL_RUN)) |-> cli_q >= $past(cli_q));
endmodule

// File: rtl/stb_emitter.sv
module stb_emitter #(
  parameter int N_CLIENTS = 14,
  parameter int N_SLOTS   = 64,
  parameter int CID_W     = 4,
  parameter int SLOT_W    = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  logic [N_CLIENTS-1:0] active_i,
  input  logic [CID_W-1:0]     tbl_client_i,
  output logic [SLOT_W-1:0]    rd_idx_o,
  output logic                 wr_en_o,
  output logic [SLOT_W-1:0]    wr_idx_o,
  output logic [CID_W-1:0]     wr_client_o,
  output logic                 busy_o,
  output logic                 done_o
);
  localparam logic [CID_W-1:0]  SENT     = '1;
  localparam logic [CID_W-1:0]  LAST_CLI = CID_W'(N_CLIENTS - 1);
  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(N_SLOTS - 1);

  logic              run_q, done_q;
  logic [SLOT_W-1:0] idx_q;
  logic [CID_W-1:0]  rr_q, sel;
  logic              found, fill;

  stb_rr_pick #(.N_CLIENTS(N_CLIENTS), .CID_W(CID_W)) u_pick (
    .active_i (active_i),
    .ptr_i    (rr_q),
    .found_o  (found),
    .sel_o    (sel)
  );

  assign fill = run_q && (tbl_client_i == SENT) && found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      rr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        run_q <= 1'b1;
        idx_q <= '0;
        rr_q  <= '0;
      end else if (run_q) begin
        idx_q <= idx_q + 1'b1;
        if (fill) rr_q <= (sel == LAST_CLI) ? '0 : sel + 1'b1;
        if (idx_q == LAST_IDX) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign rd_idx_o    = idx_q;
  assign wr_en_o     = run_q;
  assign wr_idx_o    = idx_q;
  assign wr_client_o = fill ? sel : tbl_client_i;
  assign busy_o      = run_q;
  assign done_o      = done_q;

  // R8
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> wr_idx_o == $past(wr_idx_o) + 1'b1);
  // R8
  idx_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> wr_idx_o == '0);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  empty_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_client_o == SENT) |-> !(|active_i));
  // R6
  client_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_client_o != SENT) |-> wr_client_o <= LAST_CLI);
endmodule

// File: rtl/slot_table_builder.sv
module slot_table_builder #(
  parameter int N_CLIENTS = 14,
  parameter int N_SLOTS   = 64,
  parameter int REQ_W     = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [N_CLIENTS*REQ_W-1:0] req_i,
  input  logic [N_CLIENTS-1:0]       active_i,
  input  logic [REQ_W-1:0]           unused_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       wr_en_o,
  output logic [$clog2(N_SLOTS)-1:0] wr_idx_o,
  output logic [$clog2(N_CLIENTS+1)-1:0] wr_client_o
);
  localparam int SLOT_W = $clog2(N_SLOTS);
  localparam int CID_W  = $clog2(N_CLIENTS + 1);

  logic                 pl_busy, pl_fin, em_busy, start_ok;
  logic [SLOT_W-1:0]    rd_idx;
  logic [CID_W-1:0]     rd_client;
  logic [N_CLIENTS-1:0] act;

  assign start_ok = start_i && !busy_o;
  assign busy_o   = pl_busy || em_busy;

  stb_placer #(
    .N_CLIENTS(N_CLIENTS), .N_SLOTS(N_SLOTS), .REQ_W(REQ_W),
    .CID_W(CID_W), .SLOT_W(SLOT_W)
  ) u_placer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_ok),
    .req_i       (req_i),
    .active_i    (active_i),
    .unused_i    (unused_i),
    .rd_idx_i    (rd_idx),
    .rd_client_o (rd_client),
    .act_o       (act),
    .busy_o      (pl_busy),
    .fin_o       (pl_fin)
  );

  stb_emitter #(
    .N_CLIENTS(N_CLIENTS), .N_SLOTS(N_SLOTS), .CID_W(CID_W), .SLOT_W(SLOT_W)
  ) u_emitter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (pl_fin),
    .active_i     (act),
    .tbl_client_i (rd_client),
    .rd_idx_o     (rd_idx),
    .wr_en_o      (wr_en_o),
    .wr_idx_o     (wr_idx_o),
    .wr_client_o  (wr_client_o),
    .busy_o       (em_busy),
    .done_o       (done_o)
  );

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R8
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(wr_en_o) && $past(wr_idx_o) == SLOT_W'(N_SLOTS - 1)));
  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok) |=> busy_o);
endmodule

// File: tb/sim_slot_table_builder.sv
module sim_slot_table_builder;
  localparam int NC = 14;
  localparam int NS = 64;
  localparam int RW = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [NC*RW-1:0] req_i = '0;
  logic [NC-1:0] active_i = '0;
  logic [RW-1:0] unused_i = '0;
  logic busy_o, done_o, wr_en_o;
  logic [5:0] wr_idx_o;
  logic [3:0] wr_client_o;

  always #2.5 clk = ~clk;

  slot_table_builder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .req_i(req_i),
    .active_i(active_i), .unused_i(unused_i), .busy_o(busy_o),
    .done_o(done_o), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
    .wr_client_o(wr_client_o)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  int m_req [NC];
  bit m_act [NC];
  int m_unused;
  int exp_tbl [NS];
  int got_tbl [NS];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic build_model();
    int rr;
    for (int s = 0; s < NS; s++) exp_tbl[s] = 15;
    for (int c = 0; c < NC; c++) begin
      int want, iv, pos, cnt;
      want = (m_req[c] != 0) ? m_req[c] : ((m_act[c] && m_unused > 0) ? 1 : 0);
      iv = (m_req[c] == 0) ? NS : NS / m_req[c];
      if (iv < 1) iv = 1;
      pos = 0; cnt = 0;
      while (cnt < want && pos < NS) begin
        if (exp_tbl[pos] != 15) pos++;
        else begin exp_tbl[pos] = c; cnt++; pos += iv; end
      end
    end
    rr = 0;
    for (int s = 0; s < NS; s++) begin
      if (exp_tbl[s] == 15) begin
        for (int k = 0; k < NC; k++) begin
          int j;
          j = (rr + k) % NC;
          if (m_act[j]) begin exp_tbl[s] = j; rr = (j + 1) % NC; break; end
        end
      end
    end
  endtask

  task automatic apply_inputs();
    for (int c = 0; c < NC; c++) req_i[c*RW +: RW] = RW'(m_req[c]);
    for (int c = 0; c < NC; c++) active_i[c] = m_act[c];
    unused_i = RW'(m_unused);
  endtask

  // runs one build; disturb=1 pulses start and scrambles inputs mid-run (R2)
  task automatic run_case(input string tag, input bit disturb);
    int nwr, last_idx, cyc, mism, first_bad;
    bit busy_ok, order_ok, seen_done;
    build_model();
    apply_inputs();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o, "R9 busy after start", busy_o, 1);
    if (disturb) begin
      for (int c = 0; c < NC; c++) req_i[c*RW +: RW] = RW'(3);
      active_i = '1; unused_i = RW'(5);
      start_i = 1'b1;
    end
    nwr = 0; last_idx = -1; busy_ok = 1; order_ok = 1; seen_done = 0; cyc = 0;
    for (int s = 0; s < NS; s++) got_tbl[s] = -1;
    while (!seen_done && cyc < 3000) begin
      if (done_o) begin
        seen_done = 1;
        chk(!busy_o, "R9 busy low at done", busy_o, 0);
        chk(last_idx == NS - 1 && nwr == NS, "R9 done after last write", last_idx, NS - 1);
      end else begin
        if (!busy_o) busy_ok = 0;
        if (wr_en_o) begin
          if (int'(wr_idx_o) != last_idx + 1) order_ok = 0;
          last_idx = int'(wr_idx_o);
          got_tbl[wr_idx_o] = int'(wr_client_o);
          nwr++;
        end else if (nwr > 0) order_ok = 0;
        @(negedge clk);
        if (disturb && cyc == 3) start_i = 1'b0;
        cyc++;
      end
    end
    start_i = 1'b0;
    chk(seen_done, {"R9 done seen ", tag}, seen_done, 1);
    chk(busy_ok, {"R9 busy held ", tag}, busy_ok, 1);
    chk(order_ok && nwr == NS, {"R8 write sequence ", tag}, nwr, NS);
    mism = 0; first_bad = -1;
    for (int s = 0; s < NS; s++)
      if (got_tbl[s] != exp_tbl[s]) begin mism++; if (first_bad < 0) first_bad = s; end
    if (first_bad < 0) chk(1, tag, 0, 0);
    else chk(0, {tag, " table slot"}, got_tbl[first_bad], exp_tbl[first_bad]);
    @(negedge clk);
    chk(!done_o, "R9 done one cycle", done_o, 0);
  endtask

  task automatic clear_model();
    for (int c = 0; c < NC; c++) begin m_req[c] = 0; m_act[c] = 0; end
    m_unused = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1
    chk(!busy_o && !done_o && !wr_en_o, "R1 reset outputs", {busy_o, done_o, wr_en_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !wr_en_o, "R1 idle after reset", {busy_o, done_o, wr_en_o}, 0);

    // R7: nothing active, nothing requested
    clear_model();
    run_case("R7 all empty", 0);

    // R4: collision of client 2 on client 0's slot 0
    clear_model();
    m_req[0] = 4; m_req[2] = 3; m_act[5] = 1; m_act[9] = 1;
    run_case("R4 collision shift", 0);

    // R5: zero-request active clients seeded when spare > 0
    clear_model();
    m_req[1] = 2; m_act[3] = 1; m_act[7] = 1; m_act[13] = 1; m_unused = 62;
    run_case("R5 zero request seeded", 0);

    // R5: same with spare == 0
    m_unused = 0;
    run_case("R5 zero request skipped", 0);

    // R5/R3: inactive client with nonzero request still placed
    clear_model();
    m_req[6] = 5; m_act[0] = 1;
    run_case("R3 inactive requester placed", 0);

    // R3: full table by one client, and request above table size
    clear_model();
    m_req[0] = 64; m_act[4] = 1;
    run_case("R3 full request", 0);
    clear_model();
    m_req[3] = 100; m_req[8] = 2; m_act[1] = 1;
    run_case("R3 oversize request", 0);

    // R6: round-robin only, wrap across 13 -> 0
    clear_model();
    m_act[0] = 1; m_act[12] = 1; m_act[13] = 1;
    run_case("R6 round robin wrap", 0);

    // R2: start and input changes while busy are ignored
    clear_model();
    m_req[2] = 8; m_act[2] = 1; m_act[10] = 1; m_unused = 1;
    run_case("R2 restart ignored", 1);

    for (int t = 0; t < 30; t++) begin
      for (int c = 0; c < NC; c++) begin
        m_req[c] = ($urandom % 3 == 0) ? int'($urandom % 9) : 0;
        m_act[c] = ($urandom % 2) == 1;
      end
      m_unused = int'($urandom % 65);
      if (t % 7 == 0) m_req[$urandom % NC] = int'($urandom % 70);
      run_case("R6 random mix", 0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule